// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing Ethernet frames from host memory to a byte-stream output. The host places 8-byte transmit descriptors in a circular ring, hands each one over by setting its ownership flag, and programs the ring base, the ring length and an optional poll interval through a small write-only register port. A write-one command bit, or the expiry of the poll timer, makes the engine look at the current descriptor.

For each descriptor the host owns, the engine reads the descriptor over a byte-wide memory port with a request/ready handshake. It then reads the buffer and emits the bytes with start and end markers. Finally it writes the descriptor back with ownership returned and pulses an interrupt. A frame may span several descriptors. The engine follows the chain on its own until it reaches the descriptor that carries the end flag. When no output link is attached, the bytes are dropped but the descriptor is still written back.

Configuration registers (write address `cfg_addr`): 0 ring base address, 1 ring length in descriptors, 2 poll interval in clock cycles, 3 command (bit 0 requests a transmission, bit 1 clears the done flag).

Top module: `txring_engine`

## Requirements
- R1: A descriptor is 8 bytes. Bytes 0..2 hold the 24-bit buffer address, least significant byte first. Byte 3 bit 7 is ownership (1 = engine owns it), bit 1 marks the first descriptor of a frame and bit 0 the last. Bytes 4..5 hold the two's-complement negation of the buffer byte count, least significant byte first.
- R2: The descriptor address is ring base + 8 × `cur_idx`. After each write-back the index steps by one and returns to 0 when it reaches the ring length; a length of 0 behaves as 1.
- R3: Buffer bytes leave on `tx_data` in ascending address order, one per `tx_valid` cycle. `tx_sop` is high on the first byte of a first-of-frame descriptor, and `tx_eop` is high on the last byte of a last-of-frame descriptor.
- R4: On write-back, bytes 0..2 and 4..5 are rewritten unchanged. Byte 3 becomes 0 in bit 7 and bits 6..2, with bits 1..0 kept. Bytes 6..7 are written as zero.
- R5: Each write-back is followed by a one-cycle `tx_irq` pulse. Each pulse sets `done_flag`, which stays high until a command write with bit 1 set.
- R6: A command write with bit 0 set raises `demand_pending`. A command write with bit 0 clear leaves it unchanged. The engine clears it in the cycle it starts examining a descriptor.
- R7: A request that arrives while a frame is in progress is held. It is served only after the current frame ends.
- R8: A nonzero poll interval N requests an examination every N cycles. An interval of 0 disables polling.
- R9: A descriptor whose ownership bit is 0 is left alone: no bytes, no write-back, no interrupt, and the index stays put.
- R10: After writing back a descriptor without the last-of-frame flag, the engine fetches the next descriptor with no new request.
- R11: With `link_up` low, a descriptor the engine owns produces no output bytes. It is still written back, raises the interrupt and advances the index.
- R12: After reset the outputs `tx_valid`, `tx_irq`, `mem_req`, `done_flag` and `demand_pending` are low and `cur_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| link_up | input | 1 | Output link attached |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid when `mem_ready` is high |
| mem_ready | input | 1 | Completes the access this cycle |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Last byte of frame |
| tx_irq | output | 1 | One-cycle transmit-done pulse |
| done_flag | output | 1 | Sticky transmit-done status |
| demand_pending | output | 1 | Transmit request waiting |
| cur_idx | output | LW | Current descriptor index |

## Verification
On every cycle the assertions check several properties. The interrupt is a single-cycle pulse. Frame markers only ride on valid bytes. The index moves only by one or back to zero. Every byte-3 write-back carries a cleared ownership bit. The request bit only drops when the engine accepts it. The poll pulse never repeats on consecutive cycles. Only the bench scenarios can show end-to-end behaviour against a memory with random stalls. They cover the byte stream and its markers, the exact write-back image, chaining across descriptors, skipping of host-owned descriptors, ring wrap, timer-driven starts, dropping of frames with the link down, and a request held during a busy frame.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int ADDR_W        = 24;
    localparam int DESC_BYTES    = 8;
    localparam int DESC_RD_BYTES = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_DATA,
        ST_WB,
        ST_DONE
    } txr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic              own;
        logic [4:0]        rsvd;
        logic              sop;
        logic              eop;
        logic [15:0]       neg_len;
    } txr_desc_t;

    // Fetched descriptor bytes 0..5 are packed with byte k at bits [8k+7:8k].
    function automatic txr_desc_t desc_decode(input logic [8*DESC_RD_BYTES-1:0] raw);
        txr_desc_t d;
        d.buf_addr = raw[23:0];
        d.own      = raw[31];
        d.rsvd     = raw[30:26];
        d.sop      = raw[25];
        d.eop      = raw[24];
        d.neg_len  = raw[47:32];
        return d;
    endfunction

    function automatic logic [7:0] desc_encode_byte(input txr_desc_t d, input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0:    b = d.buf_addr[7:0];
            3'd1:    b = d.buf_addr[15:8];
            3'd2:    b = d.buf_addr[23:16];
            3'd3:    b = {d.own, 5'b0, d.sop, d.eop};
            3'd4:    b = d.neg_len[7:0];
            3'd5:    b = d.neg_len[15:8];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic [15:0] byte_count(input txr_desc_t d);
        return 16'(~d.neg_len + 16'd1);
    endfunction

endpackage

// File: rtl/txr_poll.sv
module txr_poll #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] ivl,
    input  logic          reload,
    output logic          fire
);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || reload || ivl == '0) begin
            cnt  <= ivl;
            fire <= 1'b0;
        end else if (cnt <= PW'(1)) begin
            cnt  <= ivl;
            fire <= 1'b1;
        end else begin
            cnt  <= cnt - PW'(1);
            fire <= 1'b0;
        end
    end

    AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fire && ivl > PW'(1) && !reload) |=> !fire) else $error("poll pulse repeated"); // R8

endmodule

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int LW = 16,
    parameter int PW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              poll_fire,
    input  logic              start_ack,
    input  logic              irq_in,
    output logic [ADDR_W-1:0] ring_base,
    output logic [LW-1:0]     ring_len,
    output logic [PW-1:0]     poll_ivl,
    output logic              ivl_load,
    output logic              start_req,
    output logic              demand,
    output logic              done_flag
);

    localparam logic [1:0] A_BASE = 2'd0;
    localparam logic [1:0] A_LEN  = 2'd1;
    localparam logic [1:0] A_IVL  = 2'd2;
    localparam logic [1:0] A_CMD  = 2'd3;

    logic cmd_wr, demand_set, done_clr, poll_pend;
    logic cfg_hi_unused;

    assign cmd_wr        = cfg_we && cfg_addr == A_CMD;
    assign demand_set    = cmd_wr && cfg_wdata[0];
    assign done_clr      = cmd_wr && cfg_wdata[1];
    assign ivl_load      = cfg_we && cfg_addr == A_IVL;
    assign cfg_hi_unused = ^{cfg_wdata[ADDR_W-1:LW], cfg_wdata[ADDR_W-1:PW]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_base <= '0;
            ring_len  <= '0;
            poll_ivl  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_BASE:  ring_base <= cfg_wdata;
                A_LEN:   ring_len  <= cfg_wdata[LW-1:0];
                A_IVL:   poll_ivl  <= cfg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            demand    <= 1'b0;
            poll_pend <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            demand    <= (demand && !start_ack) || demand_set;
            poll_pend <= (poll_pend && !start_ack) || poll_fire;
            done_flag <= (done_flag && !done_clr) || irq_in;
        end
    end

    assign start_req = demand || poll_pend;

    AST_DEMAND_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(demand) |-> $past(start_ack)) else $error("demand dropped without start"); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(done_flag) |-> $past(done_clr)) else $error("done flag lost"); // R5

endmodule

// File: rtl/txr_fsm.sv
module txr_fsm
    import txr_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LW-1:0]     ring_len,
    input  logic              link_up,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              start_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_irq,
    output logic [LW-1:0]     cur_idx
);

    localparam logic [2:0] LAST_RD = 3'(DESC_RD_BYTES - 1);
    localparam logic [2:0] LAST_WB = 3'(DESC_BYTES - 1);

    txr_state_e                  state;
    logic [2:0]                  bcnt;
    logic [15:0]                 dcnt;
    logic [8*DESC_RD_BYTES-1:0]  raw;
    logic [LW-1:0]               idx;
    txr_desc_t                   d, wb;
    logic [15:0]                 nbytes;
    logic [ADDR_W-1:0]           desc_addr;
    logic [LW:0]                 idx_inc;
    logic [LW-1:0]               idx_nxt;
    logic                        xfer, last_byte;
    logic                        desc_rsvd_unused;

    assign d                = desc_decode(raw);
    assign desc_rsvd_unused = ^d.rsvd;
    assign nbytes           = byte_count(d);
    assign desc_addr        = ring_base + (ADDR_W'(idx) << 3);
    assign idx_inc          = {1'b0, idx} + (LW+1)'(1);
    assign idx_nxt          = (idx_inc >= {1'b0, ring_len}) ? '0 : idx_inc[LW-1:0];
    assign last_byte        = dcnt == nbytes - 16'd1;

    always_comb begin
        wb     = d;
        wb.own = 1'b0;
    end

    assign mem_req   = state == ST_FETCH || state == ST_DATA || state == ST_WB;
    assign mem_we    = state == ST_WB;
    assign mem_addr  = (state == ST_DATA) ? d.buf_addr + ADDR_W'(dcnt)
                                          : desc_addr + ADDR_W'(bcnt);
    assign mem_wdata = desc_encode_byte(wb, bcnt);
    assign xfer      = mem_req && mem_ready;
    assign start_ack = state == ST_IDLE && start_req;
    assign tx_irq    = state == ST_DONE;
    assign cur_idx   = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bcnt     <= '0;
            dcnt     <= '0;
            raw      <= '0;
            idx      <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_sop   <= 1'b0;
            tx_eop   <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_sop   <= 1'b0;
            tx_eop   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state <= ST_FETCH;
                        bcnt  <= '0;
                    end
                end
                ST_FETCH: begin
                    if (xfer) begin
                        raw[{bcnt, 3'b000} +: 8] <= mem_rdata;
                        if (bcnt == LAST_RD) state <= ST_CHECK;
                        else                 bcnt  <= bcnt + 3'd1;
                    end
                end
                ST_CHECK: begin
                    if (!d.own) begin
                        state <= ST_IDLE;
                    end else if (link_up && nbytes != 16'd0) begin
                        state <= ST_DATA;
                        dcnt  <= '0;
                    end else begin
                        state <= ST_WB;
                        bcnt  <= '0;
                    end
                end
                ST_DATA: begin
                    if (xfer) begin
                        tx_valid <= 1'b1;
                        tx_data  <= mem_rdata;
                        tx_sop   <= d.sop && dcnt == 16'd0;
                        tx_eop   <= d.eop && last_byte;
                        if (last_byte) begin
                            state <= ST_WB;
                            bcnt  <= '0;
                        end else begin
                            dcnt <= dcnt + 16'd1;
                        end
                    end
                end
                ST_WB: begin
                    if (xfer) begin
                        if (bcnt == LAST_WB) state <= ST_DONE;
                        else                 bcnt  <= bcnt + 3'd1;
                    end
                end
                ST_DONE: begin
                    idx   <= idx_nxt;
                    bcnt  <= '0;
                    state <= d.eop ? ST_IDLE : ST_FETCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq) else $error("irq longer than one cycle"); // R5

    AST_MARK_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        (tx_sop || tx_eop) |-> tx_valid) else $error("marker without byte"); // R3

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx) |-> (idx == '0 || idx == $past(idx) + LW'(1))) else $error("index jump"); // R2

    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr == desc_addr + ADDR_W'(3)) |-> !mem_wdata[7])
        else $error("ownership not returned"); // R4

    AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_ack |-> !mem_req) else $error("memory access while idle"); // R9

endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txr_pkg::*;
#(
    parameter int LW = 16,
    parameter int PW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              link_up,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_irq,
    output logic              done_flag,
    output logic              demand_pending,
    output logic [LW-1:0]     cur_idx
);

    logic [ADDR_W-1:0] ring_base;
    logic [LW-1:0]     ring_len;
    logic [PW-1:0]     poll_ivl;
    logic              ivl_load, poll_fire, start_req, start_ack;

    txr_regs #(.LW(LW), .PW(PW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .poll_fire (poll_fire),
        .start_ack (start_ack),
        .irq_in    (tx_irq),
        .ring_base (ring_base),
        .ring_len  (ring_len),
        .poll_ivl  (poll_ivl),
        .ivl_load  (ivl_load),
        .start_req (start_req),
        .demand    (demand_pending),
        .done_flag (done_flag)
    );

    txr_poll #(.PW(PW)) u_poll (
        .clk    (clk),
        .rst    (rst),
        .ivl    (poll_ivl),
        .reload (ivl_load),
        .fire   (poll_fire)
    );

    txr_fsm #(.LW(LW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .ring_base (ring_base),
        .ring_len  (ring_len),
        .link_up   (link_up),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .start_ack (start_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_sop    (tx_sop),
        .tx_eop    (tx_eop),
        .tx_irq    (tx_irq),
        .cur_idx   (cur_idx)
    );

endmodule

// File: tb/txring_engine_bench.sv
`timescale 1ns/1ps
module txring_engine_bench;

    localparam int LW = 16;
    localparam int PW = 16;
    localparam int BASE = 'h100;
    localparam int RLEN = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        link_up = 1'b1;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        tx_valid, tx_sop, tx_eop, tx_irq, done_flag, demand_pending;
    logic [7:0]  tx_data;
    logic [LW-1:0] cur_idx;

    logic [7:0] mem [0:4095];
    logic [9:0] got [$];
    logic [9:0] expq [$];
    int checks = 0, fails = 0, irq_cnt = 0, exp_irq = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    txring_engine #(.LW(LW), .PW(PW)) u_txring_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .link_up(link_up), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_irq(tx_irq), .done_flag(done_flag), .demand_pending(demand_pending),
        .cur_idx(cur_idx)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) if (mem_req && mem_we && mem_ready) mem[mem_addr[11:0]] <= mem_wdata;

    always @(negedge clk) begin
        mem_ready <= ($urandom_range(3) != 0);
        if (tx_valid) got.push_back({tx_sop, tx_eop, tx_data});
        if (tx_irq) irq_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int daddr(input int idx);
        return BASE + idx * 8;
    endfunction

    task automatic put_desc(input int idx, input int bufa, input int n, input bit own,
                            input bit stp, input bit enp, input bit expect_tx);
        int a = daddr(idx);
        logic [15:0] neg = 16'(-n);
        mem[a]   = bufa[7:0];
        mem[a+1] = bufa[15:8];
        mem[a+2] = bufa[23:16];
        mem[a+3] = {own, 5'b0, stp, enp};
        mem[a+4] = neg[7:0];
        mem[a+5] = neg[15:8];
        mem[a+6] = 8'hAA;
        mem[a+7] = 8'hAA;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'($urandom);
            mem[bufa + i] = b;
            if (expect_tx) expq.push_back({stp && i == 0, enp && i == n - 1, b});
        end
    endtask

    task automatic check_frame(input string req);
        chk(got.size() == expq.size(), req, "frame length", got.size(), expq.size());
        if (got.size() == expq.size())
            for (int i = 0; i < got.size(); i++)
                chk(got[i] == expq[i], req, "frame entry {sop,eop,byte}", got[i], expq[i]);
        got.delete();
        expq.delete();
    endtask

    task automatic check_wb(input int idx, input int bufa, input int n, input bit stp,
                            input bit enp, input string req);
        int a = daddr(idx);
        chk({mem[a+2], mem[a+1], mem[a]} == 24'(bufa), req, "wb address", {mem[a+2], mem[a+1], mem[a]}, bufa);
        chk(mem[a+3] == {6'b0, stp, enp}, req, "wb flag byte", mem[a+3], {6'b0, stp, enp});
        chk({mem[a+5], mem[a+4]} == 16'(-n), req, "wb size", {mem[a+5], mem[a+4]}, 16'(-n));
        chk({mem[a+7], mem[a+6]} == 16'h0, req, "wb tail", {mem[a+7], mem[a+6]}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int ei;
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(!tx_valid && !tx_irq && !mem_req, "R12", "outputs idle in reset", {tx_valid, tx_irq, mem_req}, 0);
        chk(!done_flag && !demand_pending, "R12", "flags clear", {done_flag, demand_pending}, 0);
        chk(cur_idx == 0, "R12", "index", cur_idx, 0);
        rst = 1'b0;
        cfg(2'd0, 24'(BASE));
        cfg(2'd1, 24'(RLEN));
        cfg(2'd2, 24'd0);

        // R1 R3 single-descriptor frame by demand
        put_desc(0, 'h400, 5, 1, 1, 1, 1);
        cfg(2'd3, 24'd1);
        repeat (400) @(negedge clk);
        check_frame("R3");
        check_wb(0, 'h400, 5, 1, 1, "R4");
        chk(cur_idx == 1, "R2", "index after one", cur_idx, 1);
        exp_irq++;
        chk(irq_cnt == exp_irq, "R5", "irq count", irq_cnt, exp_irq);
        chk(done_flag, "R5", "done flag set", done_flag, 1);
        chk(!demand_pending, "R6", "demand cleared on start", demand_pending, 0);
        cfg(2'd3, 24'd2);
        chk(!done_flag, "R5", "done flag cleared", done_flag, 0);

        // R6 writing zero to the demand bit does nothing
        put_desc(1, 'h500, 4, 1, 1, 1, 0);
        cfg(2'd3, 24'd0);
        chk(!demand_pending, "R6", "zero write", demand_pending, 0);
        repeat (300) @(negedge clk);
        chk(cur_idx == 1 && got.size() == 0, "R6", "no transmit after zero write", cur_idx, 1);

        // R9 host-owned descriptor is skipped
        put_desc(1, 'h500, 4, 0, 1, 1, 0);
        cfg(2'd3, 24'd1);
        repeat (300) @(negedge clk);
        chk(cur_idx == 1, "R9", "index held", cur_idx, 1);
        chk(got.size() == 0, "R9", "no bytes", got.size(), 0);
        chk(irq_cnt == exp_irq, "R9", "no irq", irq_cnt, exp_irq);
        chk(mem[daddr(1)+6] == 8'hAA, "R9", "no write-back", mem[daddr(1)+6], 8'hAA);
        chk(!demand_pending, "R9", "demand consumed", demand_pending, 0);

        // R10 chained frame over two descriptors
        put_desc(1, 'h500, 3, 1, 1, 0, 1);
        put_desc(2, 'h600, 4, 1, 0, 1, 1);
        cfg(2'd3, 24'd1);
        repeat (600) @(negedge clk);
        check_frame("R10");
        chk(cur_idx == 3, "R10", "index after chain", cur_idx, 3);
        exp_irq += 2;
        chk(irq_cnt == exp_irq, "R10", "two irqs", irq_cnt, exp_irq);
        check_wb(1, 'h500, 3, 1, 0, "R4");

        // R2 ring wrap
        put_desc(3, 'h700, 2, 1, 1, 1, 1);
        cfg(2'd3, 24'd1);
        repeat (400) @(negedge clk);
        check_frame("R2");
        chk(cur_idx == 0, "R2", "index wraps", cur_idx, 0);
        exp_irq++;

        // R8 poll timer starts a transmission
        put_desc(0, 'h400, 6, 1, 1, 1, 1);
        cfg(2'd2, 24'd40);
        repeat (500) @(negedge clk);
        cfg(2'd2, 24'd0);
        repeat (50) @(negedge clk);
        check_frame("R8");
        chk(cur_idx == 1, "R8", "index after poll", cur_idx, 1);
        exp_irq++;
        chk(irq_cnt == exp_irq, "R8", "irq count", irq_cnt, exp_irq);

        // R8 interval zero means no polling; R11 link down drops bytes
        put_desc(1, 'h500, 4, 1, 1, 1, 0);
        repeat (300) @(negedge clk);
        chk(cur_idx == 1, "R8", "no poll when disabled", cur_idx, 1);
        link_up = 1'b0;
        cfg(2'd3, 24'd1);
        repeat (400) @(negedge clk);
        chk(got.size() == 0, "R11", "no bytes with link down", got.size(), 0);
        check_wb(1, 'h500, 4, 1, 1, "R11");
        chk(cur_idx == 2, "R11", "index advanced", cur_idx, 2);
        exp_irq++;
        chk(irq_cnt == exp_irq, "R11", "irq raised", irq_cnt, exp_irq);
        link_up = 1'b1;

        // R7 demand during a busy frame is held
        put_desc(2, 'h800, 40, 1, 1, 1, 1);
        put_desc(3, 'h900, 4, 0, 1, 1, 0);
        cfg(2'd3, 24'd1);
        repeat (28) @(negedge clk);
        cfg(2'd3, 24'd1);
        chk(demand_pending, "R7", "demand held while busy", demand_pending, 1);
        repeat (600) @(negedge clk);
        check_frame("R7");
        chk(!demand_pending, "R7", "held demand served", demand_pending, 0);
        chk(cur_idx == 3, "R7", "index after retry skip", cur_idx, 3);
        exp_irq++;
        chk(irq_cnt == exp_irq, "R7", "single irq", irq_cnt, exp_irq);

        // R1 R3 random frames
        ei = 3;
        for (int it = 0; it < 8; it++) begin
            int n = 1 + $urandom_range(19);
            int bufa = 'hA00 + it * 'h40;
            put_desc(ei, bufa, n, 1, 1, 1, 1);
            cfg(2'd3, 24'd1);
            repeat (400) @(negedge clk);
            check_frame("R1");
            check_wb(ei, bufa, n, 1, 1, "R4");
            ei = (ei + 1) % RLEN;
            chk(cur_idx == LW'(ei), "R2", "random index", cur_idx, ei);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule